// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block times an external signal in units of a divided internal clock. Software picks a count clock of the system clock divided by 4, 16 or 32, and a measurement mode: high time, low time, rising-to-rising period or falling-to-falling period. It then sets the start command. The counter is cleared on the opening edge and advances once per count-clock tick. On the closing edge the count is captured into a result register and the done flag is set.

The external input is synchronized first. It can then go straight to the edge detector or pass through a divider of 4, 16, 64 or 256. The divider lets a long series of short periods be measured as one long interval. A counter wrap during a measurement sets a sticky overflow flag. Each flag drives its own interrupt line through an enable bit.

Software reaches the block through a small register port with three registers: control, status/command and result. Reading the result clears the done flag.

Top module: `pwc_timer`

## Requirements
- R1: Control bits [1:0] select the count clock: 00 gives one tick every 4 system clocks, 01 every 16, and 10 or 11 every 32. The prescaler runs freely from reset.
- R2: A measurement's result equals the number of count-clock ticks seen after the opening edge, up to but not including the cycle of the closing edge. For a pulse of W system clocks, this is within one of W divided by the tick spacing.
- R3: Control bits [3:2] pick the edges. 0: high time (rise opens, fall closes). 1: low time (fall opens, rise closes). 2: rise to rise. 3: fall to fall.
- R4: Control bit 4 enables the input divider and bits [6:5] pick its ratio: 00 = 4, 01 = 16, 10 = 64, 11 = 256. When the divider is enabled, the measured signal is bit 1, 3, 5 or 7 of a count of synchronized rising input edges. When bit 4 is 0, the synchronized input is measured directly.
- R5: The counter is CNT_W bits wide and wraps to zero. A wrap while measuring sets the overflow flag (status bit 2).
- R6: The overflow flag stays set until a status write with bit 2 equal to 0 clears it. A status write with bit 2 equal to 1 leaves it unchanged, and a new overflow in the same cycle wins over the clear.
- R7: A closing edge sets the done flag (status bit 1) and loads the result register (address 2). A read of address 2 clears the done flag, unless a closing edge sets it in that same cycle. Writes to address 2 have no effect.
- R8: irq_ovf_o is the overflow flag ANDed with control bit 8. irq_done_o is the done flag ANDed with control bit 9. Both are registered one cycle behind the flags.
- R9: Writing status with bit 0 set arms the block, and status bit 0 (busy) reads 1. The count starts from zero at the opening edge, and busy returns to 0 after the closing edge.
- R10: Writing status with bit 1 set returns the block to idle. This has priority over the start bit and over a closing edge in the same cycle. The done flag is not set and the result is not changed.
- R11: The input passes through a two-flop synchronizer before the divider and edge detection.
- R12: Address 0 reads back the control bits (bit 7 reads 0), address 1 reads {ovf, done, busy} in bits [2:0], and address 2 reads the result. reg_rdata changes only on the clock after a read strobe and holds otherwise. All flags and registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status/command, 2 result |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| pin_i | input | 1 | External signal under measurement |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_done_o | output | 1 | Measurement-complete interrupt request |

## Verification
The assertions assume that reset is held for at least one clock and that the read and write strobes come from a single master, so at most one register access is made per cycle. They also assume that pin_i changes at most once per clock, as sampled by the synchronizer. The stimulus changes the control register only while the block is idle and before the start command. This avoids a divider-select change being measured as an edge. It drives the pin and the strobes on the falling clock edge.

// File: rtl/pwct_pkg.sv
package pwct_pkg;

  localparam int unsigned DIV_SEL_W = 2;
  localparam int unsigned DIV_OPTS  = 1 << DIV_SEL_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2
  } pwct_state_e;

  typedef enum logic [1:0] {
    MD_HIGH = 2'd0,
    MD_LOW  = 2'd1,
    MD_RISE = 2'd2,
    MD_FALL = 2'd3
  } pwct_mode_e;

  typedef struct packed {
    logic                 done_ie;
    logic                 ovf_ie;
    logic                 spare;
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 div_en;
    pwct_mode_e           mode;
    logic [1:0]           clk_sel;
  } pwct_ctrl_t;

  localparam int unsigned CTRL_W    = $bits(pwct_ctrl_t);
  localparam logic [CTRL_W-1:0] CTRL_MASK = 10'h37F;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_RES  = 2;

  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_STOP  = 1;
  localparam int unsigned CMD_OVF   = 2;

endpackage

// File: rtl/pwct_prescaler.sv
module pwct_prescaler #(
  parameter int unsigned PS_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel_i,
  output logic       tick_o
);

  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    case (sel_i)
      2'b00:   mask = PS_W'(3);
      2'b01:   mask = PS_W'(15);
      default: mask = '1;
    endcase
  end

  assign tick_o = (cnt_q & mask) == mask;

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R1

endmodule

// File: rtl/pwct_input_path.sv
module pwct_input_path #(
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned DIV_OPTS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        pin_i,
  input  logic                        div_en_i,
  input  logic [$clog2(DIV_OPTS)-1:0] div_sel_i,
  output logic                        rise_o,
  output logic                        fall_o
);

  localparam int unsigned EC_W = 2 * DIV_OPTS;

  logic [SYNC_N-1:0]   sync_q;
  logic                s_cur;
  logic                s_prev_q;
  logic [EC_W-1:0]     ec_q;
  logic [DIV_OPTS-1:0] taps;
  logic                meas;
  logic                meas_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-2:0], pin_i};
  end

  assign s_cur = sync_q[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      s_prev_q <= 1'b0;
      ec_q     <= '0;
      meas_q   <= 1'b0;
    end else begin
      s_prev_q <= s_cur;
      if (s_cur && !s_prev_q) ec_q <= ec_q + 1'b1;
      meas_q   <= meas;
    end
  end

  generate
    for (genvar g = 0; g < DIV_OPTS; g++) begin : g_tap
      assign taps[g] = ec_q[2*g+1];
    end
  endgenerate

  assign meas   = div_en_i ? taps[div_sel_i] : s_cur;
  assign rise_o = meas && !meas_q;
  assign fall_o = !meas && meas_q;

  AST_EDGE_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(ec_q) |-> ec_q == $past(ec_q) + 1'b1); // R4

endmodule

// File: rtl/pwct_core.sv
module pwct_core
  import pwct_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  pwct_mode_e       mode_i,
  input  logic             arm_i,
  input  logic             abort_i,
  input  logic             rd_result_i,
  input  logic             ovf_clr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] result_o
);

  pwct_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_edge;
  logic             end_edge;
  logic             done_set;
  logic             ovf_set;

  always_comb begin
    case (mode_i)
      MD_HIGH: begin start_edge = rise_i; end_edge = fall_i; end
      MD_LOW:  begin start_edge = fall_i; end_edge = rise_i; end
      MD_RISE: begin start_edge = rise_i; end_edge = rise_i; end
      default: begin start_edge = fall_i; end_edge = fall_i; end
    endcase
  end

  assign done_set = (state_q == ST_MEAS) && end_edge && !abort_i && !arm_i;
  assign ovf_set  = (state_q == ST_MEAS) && !end_edge && tick_i && (&cnt_q)
                    && !abort_i && !arm_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      result_o <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
    end else if (arm_i) begin
      state_q <= ST_ARMED;
    end else begin
      case (state_q)
        ST_ARMED: if (start_edge) begin
          state_q <= ST_MEAS;
          cnt_q   <= '0;
        end
        ST_MEAS: begin
          if (end_edge) begin
            state_q  <= ST_IDLE;
            result_o <= cnt_q;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      done_o <= done_set | (done_o & ~rd_result_i);
      ovf_o  <= ovf_set | (ovf_o & ~ovf_clr_i);
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !busy_o); // R10
  AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> $stable(result_o)); // R10
  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARMED && start_edge && !abort_i && !arm_i) |=> (cnt_q == '0 && state_q == ST_MEAS)); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !rd_result_i) |=> done_o); // R7
  AST_READ_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (rd_result_i && !done_set) |=> !done_o); // R7
  AST_RESULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !done_set |=> $stable(result_o)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R6
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEAS && tick_i && (&cnt_q) && !end_edge && !abort_i && !arm_i) |=> (ovf_o && cnt_q == '0)); // R5

endmodule

// File: rtl/pwc_timer.sv
module pwc_timer
  import pwct_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned PS_W     = 5,
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned DIV_WAYS = DIV_OPTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pin_i,
  output logic              irq_ovf_o,
  output logic              irq_done_o
);

  pwct_ctrl_t       ctrl_q;
  logic             tick;
  logic             rise;
  logic             fall;
  logic             sel_ctrl;
  logic             sel_stat;
  logic             sel_res;
  logic             arm;
  logic             abort;
  logic             ovf_clr;
  logic             rd_result;
  logic             busy;
  logic             done;
  logic             ovf;
  logic [CNT_W-1:0] result;

  assign sel_ctrl  = (reg_addr == ADDR_W'(ADDR_CTRL));
  assign sel_stat  = (reg_addr == ADDR_W'(ADDR_STAT));
  assign sel_res   = (reg_addr == ADDR_W'(ADDR_RES));
  assign arm       = reg_wr && sel_stat && reg_wdata[CMD_START];
  assign abort     = reg_wr && sel_stat && reg_wdata[CMD_STOP];
  assign ovf_clr   = reg_wr && sel_stat && !reg_wdata[CMD_OVF];
  assign rd_result = reg_rd && sel_res;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (reg_wr && sel_ctrl) ctrl_q <= pwct_ctrl_t'(reg_wdata[CTRL_W-1:0] & CTRL_MASK);
  end

  pwct_prescaler #(.PS_W(PS_W)) u_prescaler (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (ctrl_q.clk_sel),
    .tick_o (tick)
  );

  pwct_input_path #(.SYNC_N(SYNC_N), .DIV_OPTS(DIV_WAYS)) u_input_path (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (pin_i),
    .div_en_i  (ctrl_q.div_en),
    .div_sel_i (ctrl_q.div_sel),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  pwct_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .rise_i      (rise),
    .fall_i      (fall),
    .mode_i      (ctrl_q.mode),
    .arm_i       (arm),
    .abort_i     (abort),
    .rd_result_i (rd_result),
    .ovf_clr_i   (ovf_clr),
    .busy_o      (busy),
    .done_o      (done),
    .ovf_o       (ovf),
    .result_o    (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      irq_ovf_o  <= 1'b0;
      irq_done_o <= 1'b0;
    end else begin
      irq_ovf_o  <= ovf & ctrl_q.ovf_ie;
      irq_done_o <= done & ctrl_q.done_ie;
      if (reg_rd) begin
        if (sel_ctrl)      reg_rdata <= DATA_W'(ctrl_q);
        else if (sel_stat) reg_rdata <= DATA_W'({ovf, done, busy});
        else if (sel_res)  reg_rdata <= DATA_W'(result);
        else               reg_rdata <= '0;
      end
    end
  end

  AST_IRQ_DONE_GATED: assert property (@(posedge clk) disable iff (rst)
    !done |=> !irq_done_o); // R8
  AST_IRQ_OVF_GATED: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.ovf_ie |=> !irq_ovf_o); // R8
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R12

endmodule

// File: tb/pwc_timer_bench.sv
module pwc_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        pin = 1'b0;
  logic        irq_ovf_o;
  logic        irq_done_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwc_timer #(.CNT_W(CNT_W)) u_pwc_timer (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pin_i      (pin),
    .irq_ovf_o  (irq_ovf_o),
    .irq_done_o (irq_done_o)
  );

  // behavioural reference model
  int m_s1, m_s2, m_s2d, m_ec, m_md, m_pc, m_st, m_cnt, m_res;
  int m_done, m_ovf, m_ctrl, m_rdata, m_iovf, m_idone;

  always @(posedge clk) begin : ref_model
    int cks, mode, den, dsel, oie, die, mo, ri, fa, se, ee, dv, tk;
    int arm, abort, oclr, rdres, dset, oset, n_st, n_cnt, n_res, n_rd;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s2d = 0; m_ec = 0; m_md = 0; m_pc = 0;
      m_st = 0; m_cnt = 0; m_res = 0; m_done = 0; m_ovf = 0; m_ctrl = 0;
      m_rdata = 0; m_iovf = 0; m_idone = 0;
    end else begin
      cks  = m_ctrl & 3;        mode = (m_ctrl >> 2) & 3;
      den  = (m_ctrl >> 4) & 1; dsel = (m_ctrl >> 5) & 3;
      oie  = (m_ctrl >> 8) & 1; die  = (m_ctrl >> 9) & 1;
      mo = den ? ((m_ec >> (2*dsel+1)) & 1) : m_s2;
      ri = (mo == 1 && m_md == 0); fa = (mo == 0 && m_md == 1);
      se = (mode == 0 || mode == 2) ? ri : fa;
      ee = (mode == 1 || mode == 2) ? ri : fa;
      dv = (cks == 0) ? 4 : (cks == 1) ? 16 : 32;
      tk = ((m_pc % dv) == dv - 1);
      arm   = reg_wr && reg_addr == 1 && reg_wdata[0];
      abort = reg_wr && reg_addr == 1 && reg_wdata[1];
      oclr  = reg_wr && reg_addr == 1 && !reg_wdata[2];
      rdres = reg_rd && reg_addr == 2;
      n_rd = m_rdata;
      if (reg_rd) begin
        case (reg_addr)
          2'd0: n_rd = m_ctrl;
          2'd1: n_rd = m_ovf*4 + m_done*2 + (m_st != 0 ? 1 : 0);
          2'd2: n_rd = m_res;
          default: n_rd = 0;
        endcase
      end
      dset = 0; oset = 0; n_st = m_st; n_cnt = m_cnt; n_res = m_res;
      if (abort) n_st = 0;
      else if (arm) n_st = 1;
      else if (m_st == 1) begin
        if (se) begin n_st = 2; n_cnt = 0; end
      end else if (m_st == 2) begin
        if (ee) begin n_st = 0; n_res = m_cnt; dset = 1; end
        else if (tk) begin
          if (m_cnt == (1 << CNT_W) - 1) oset = 1;
          n_cnt = (m_cnt + 1) % (1 << CNT_W);
        end
      end
      m_iovf  = m_ovf & oie;
      m_idone = m_done & die;
      m_done  = (dset || (m_done && !rdres)) ? 1 : 0;
      m_ovf   = (oset || (m_ovf && !oclr)) ? 1 : 0;
      m_rdata = n_rd;
      m_st = n_st; m_cnt = n_cnt; m_res = n_res;
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata & 16'h037F;
      if (m_s2 == 1 && m_s2d == 0) m_ec = (m_ec + 1) % 256;
      m_md = mo; m_s2d = m_s2; m_s2 = m_s1; m_s1 = pin;
      m_pc = (m_pc + 1) % 32;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(reg_rdata == 16'(m_rdata), "R12/R11 model rdata", reg_rdata, m_rdata);
      chk(irq_ovf_o == m_iovf[0], "R8 model irq_ovf", irq_ovf_o, m_iovf);
      chk(irq_done_o == m_idone[0], "R8 model irq_done", irq_done_o, m_idone);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 2'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 2'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic measure(input int ctrl, input int hi, input int lo, input int n, output int res);
    int st;
    wr(0, ctrl);
    wr(1, 5);
    idle(4);
    rd(1, st);
    chk(st[0] == 1'b1, "R9 busy after arm", st & 1, 1);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; idle(hi);
      pin = 1'b0; idle(lo);
    end
    idle(10);
    rd(1, st);
    chk(st[1] == 1'b1, "R7 done after closing edge", (st >> 1) & 1, 1);
    chk(st[0] == 1'b0, "R9 idle after closing edge", st & 1, 0);
    rd(2, res);
    rd(1, st);
    chk(st[1] == 1'b0, "R7 read of result clears done", (st >> 1) & 1, 0);
  endtask

  task automatic near(input int res, input int exp, input string tag);
    int diff;
    diff = res - exp;
    chk(diff >= -1 && diff <= 1, tag, res, exp);
  endtask

  initial begin
    int r, st, keep;
    idle(3);
    rst = 1'b0;
    idle(2);
    rd(0, r);  chk(r == 0, "R12 control after reset", r, 0);
    rd(1, r);  chk(r == 0, "R12 status after reset", r, 0);
    chk(irq_ovf_o == 0 && irq_done_o == 0, "R8 irqs low after reset", irq_ovf_o, 0);

    wr(0, 16'h0355);
    rd(0, r);  chk(r == 16'h0355, "R12 control readback", r, 16'h0355);

    measure(16'h0000, 40, 30, 1, r);  near(r, 10, "R2 R3 high time div4");
    measure(16'h0001, 160, 30, 1, r); near(r, 10, "R1 high time div16");
    measure(16'h0002, 320, 30, 1, r); near(r, 10, "R1 high time div32");
    measure(16'h0003, 320, 30, 1, r); near(r, 10, "R1 select 11 acts as div32");
    measure(16'h0004, 20, 48, 2, r);  near(r, 12, "R3 low time");
    measure(16'h0008, 30, 50, 2, r);  near(r, 20, "R3 rise to rise");
    measure(16'h000C, 30, 70, 2, r);  near(r, 25, "R3 fall to fall");
    measure(16'h0010, 10, 10, 8, r);  near(r, 10, "R4 input divider 4");
    measure(16'h0030, 5, 5, 32, r);   near(r, 20, "R4 input divider 16");
    keep = r;

    wr(2, 16'hFFFF);
    rd(2, r);  chk(r == keep, "R7 write to result ignored", r, keep);
    rd(2, r);
    rd(1, st); chk(st[1] == 1'b0, "R7 read while not done leaves done low", (st >> 1) & 1, 0);

    // abort
    wr(0, 16'h0000);
    wr(1, 5);
    idle(4);
    pin = 1'b1; idle(30);
    wr(1, 6);
    idle(5);
    pin = 1'b0; idle(10);
    rd(1, st); chk((st & 3) == 0, "R10 stop leaves done and busy low", st & 3, 0);
    rd(2, r);  chk(r == keep, "R10 stop keeps result", r, keep);

    // overflow, interrupts
    measure(16'h0300, 5000, 20, 1, r);
    rd(1, st); chk(st[2] == 1'b1, "R5 overflow flag after wrap", (st >> 2) & 1, 1);
    chk(irq_ovf_o == 1'b1, "R8 overflow irq enabled", irq_ovf_o, 1);
    wr(1, 16'h0004);
    rd(1, st); chk(st[2] == 1'b1, "R6 writing 1 keeps overflow", (st >> 2) & 1, 1);
    wr(1, 16'h0000);
    rd(1, st); chk(st[2] == 1'b0, "R6 writing 0 clears overflow", (st >> 2) & 1, 0);
    idle(2);
    chk(irq_ovf_o == 1'b0, "R8 overflow irq drops", irq_ovf_o, 0);

    wr(0, 16'h0200);
    wr(1, 5);
    idle(4);
    pin = 1'b1; idle(40); pin = 1'b0; idle(10);
    chk(irq_done_o == 1'b1, "R8 done irq raised", irq_done_o, 1);
    rd(2, r);  near(r, 10, "R2 result with done irq");
    idle(2);
    chk(irq_done_o == 1'b0, "R8 done irq cleared by result read", irq_done_o, 0);

    idle(5);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule